// File: doc/BRIEF.md
# Zero-Overhead Instruction Repeat Controller

This controller gives a simple in-order processor a hardware loop. A repeat command supplies an iteration count and a block length in instructions. The two instructions that follow the command run once as a delay slot. The block itself starts at the third instruction after the command. From then on the controller watches the program counter. Each time the fetch leaves the last instruction of the block while passes remain, it drives an override so that the next fetch address is the block start. The redirect happens in the same cycle as the normal advance, so a pass costs no extra cycles and the block needs no branch instruction.

A loop therefore takes `3 + L*N` fetch cycles, counting the command and the delay slot, where L is the block length and N is the number of passes. The processor uses the override whenever it is valid and otherwise steps its PC as usual. Only one loop can be active at a time.

Top module: `rpt_ctrl`

## Requirements
- R1: After reset, `busy` is 0 and `pc_ovr_valid` is 0.
- R2: A command (`cmd_valid` together with `advance`) accepted while idle sets `busy` from the next cycle. The block start is the command's `pc` plus 3, so the two instructions at `pc`+1 and `pc`+2 run exactly once.
- R3: When `pc` equals the block's last address, `advance` is high and passes remain, `pc_ovr_valid` is 1 and `pc_ovr` equals the block start in that same cycle. Command, delay slot and N passes of L instructions take exactly 3 + L*N advance cycles.
- R4: Counts from 1 up to 2**CNT_W-1 (511 by default, so at least 256) and block lengths from 1 up to 2**LEN_W-1 are supported.
- R5: A count of 0 behaves exactly like a count of 1: the block runs once and no override is issued.
- R6: At the last address of the final pass, no override is issued and `busy` is 0 from the next cycle on.
- R7: A command presented while `busy` is 1 is ignored, including in the cycle the final pass ends. Timing is unchanged and `busy` stays 0 afterwards.
- R8: While `advance` is 0, `pc_ovr_valid` is 0 and the remaining pass count is held.
- R9: A block length of 0 is treated as a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | input | PC_W | Address of the instruction fetched this cycle |
| advance | input | 1 | Fetch moves on to the next address this cycle |
| cmd_valid | input | 1 | Instruction at `pc` is a repeat command |
| cmd_count | input | CNT_W | Number of passes of the block (0 acts as 1) |
| cmd_len | input | LEN_W | Instructions in the block (0 acts as 1) |
| pc_ovr_valid | output | 1 | Next fetch address must be `pc_ovr` |
| pc_ovr | output | PC_W | Block start address to fetch next |
| busy | output | 1 | A loop is armed or running |

## Verification
A new repeat command and the end of a pass can coincide. This matters most when the command arrives in the very cycle the final pass ends, while `busy` is still high. The bench provokes this by asserting a foreign command with different parameters on every busy cycle of a run, the last one included. It then judges the result at the ports: the total advance-cycle count must still equal 3 + L*N, every override must target the original start, and `busy` must read 0 after the run. If `busy` read 1 there, the late command would have been accepted.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  localparam int PC_W  = 16;
  localparam int CNT_W = 9;
  localparam int LEN_W = 6;

  typedef logic [PC_W-1:0]  pc_t;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [LEN_W-1:0] len_t;

  // length of 0 counts as a single instruction
  function automatic len_t eff_len(input len_t l);
    return (l == '0) ? len_t'(1) : l;
  endfunction

  // first address of the block: two delay-slot instructions after the command
  function automatic pc_t block_start(input pc_t cmd_pc);
    return cmd_pc + pc_t'(3);
  endfunction

  function automatic pc_t block_last(input pc_t start, input len_t l);
    return start + pc_t'(eff_len(l)) - pc_t'(1);
  endfunction

  // loop-backs still owed after the first pass; 0 and 1 both give none
  function automatic cnt_t extra_passes(input cnt_t c);
    return (c == '0) ? '0 : c - cnt_t'(1);
  endfunction
endpackage

// File: rtl/rpt_window.sv
module rpt_window
  import rpt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  pc_t  cmd_pc,
  input  len_t cmd_len,
  input  pc_t  pc,
  output pc_t  start_pc,
  output logic at_last
);
  pc_t start_q, last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      last_q  <= '0;
    end else if (load) begin
      start_q <= block_start(cmd_pc);
      last_q  <= block_last(block_start(cmd_pc), cmd_len);
    end
  end

  assign start_pc = start_q;
  assign at_last  = (pc == last_q);
endmodule

// File: rtl/rpt_tally.sv
module rpt_tally
  import rpt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  cnt_t load_val,
  input  logic dec,
  output cnt_t left,
  output logic none_left
);
  cnt_t left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    left_q <= '0;
    else if (load) left_q <= extra_passes(load_val);
    else if (dec)  left_q <= left_q - cnt_t'(1);
  end

  assign left      = left_q;
  assign none_left = (left_q == '0);
endmodule

// File: rtl/rpt_ctrl.sv
module rpt_ctrl
  import rpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  pc,
  input  logic             advance,
  input  logic             cmd_valid,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             pc_ovr_valid,
  output logic [PC_W-1:0]  pc_ovr,
  output logic             busy
);
  logic busy_q;
  logic ev_arm, ev_pass_end, ev_loop_back, ev_finish;
  logic at_last, none_left;
  pc_t  start_pc;
  cnt_t left;

  assign ev_arm       = cmd_valid && advance && !busy_q;
  assign ev_pass_end  = busy_q && advance && at_last;
  assign ev_loop_back = ev_pass_end && !none_left;
  assign ev_finish    = ev_pass_end && none_left;

  rpt_window u_window (
    .clk(clk), .rst_n(rst_n), .load(ev_arm), .cmd_pc(pc), .cmd_len(cmd_len),
    .pc(pc), .start_pc(start_pc), .at_last(at_last)
  );

  rpt_tally u_tally (
    .clk(clk), .rst_n(rst_n), .load(ev_arm), .load_val(cmd_count),
    .dec(ev_loop_back), .left(left), .none_left(none_left)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         busy_q <= 1'b0;
    else if (ev_arm)    busy_q <= 1'b1;
    else if (ev_finish) busy_q <= 1'b0;
  end

  assign busy         = busy_q;
  assign pc_ovr_valid = ev_loop_back;
  assign pc_ovr       = start_pc;
endmodule

// File: rtl/rpt_ctrl_chk.sv
module rpt_ctrl_chk
  import rpt_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic advance,
  input logic cmd_valid,
  input logic pc_ovr_valid,
  input logic busy,
  input logic ev_arm,
  input logic ev_finish,
  input logic ev_loop_back,
  input logic at_last,
  input pc_t  start_pc,
  input cnt_t left
);
  AST_ARM_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arm |=> busy); // R2
  AST_OVR_NEEDS_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ovr_valid |-> (busy && at_last)); // R3
  AST_LOOP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_loop_back |=> (left == $past(left) - cnt_t'(1))); // R3
  AST_FINISH_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> !busy); // R6
  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(start_pc)); // R7
  AST_STALL_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |-> !pc_ovr_valid); // R8
  AST_STALL_HOLDS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !advance) |=> $stable(left)); // R8
endmodule

bind rpt_ctrl rpt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .advance(advance), .cmd_valid(cmd_valid),
  .pc_ovr_valid(pc_ovr_valid), .busy(busy), .ev_arm(ev_arm),
  .ev_finish(ev_finish), .ev_loop_back(ev_loop_back), .at_last(at_last),
  .start_pc(start_pc), .left(left)
);

// File: tb/test_rpt_ctrl.sv
module test_rpt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pc = '0;
  logic        advance = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [8:0]  cmd_count = '0;
  logic [5:0]  cmd_len = '0;
  logic        pc_ovr_valid;
  logic [15:0] pc_ovr;
  logic        busy;
  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rpt_ctrl i_rpt_ctrl (
    .clk(clk), .rst_n(rst_n), .pc(pc), .advance(advance), .cmd_valid(cmd_valid),
    .cmd_count(cmd_count), .cmd_len(cmd_len), .pc_ovr_valid(pc_ovr_valid),
    .pc_ovr(pc_ovr), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Models a processor running a loop; counts advance cycles until fall-through.
  task automatic exec(input logic [15:0] base, input int cnt, input int len,
                      input bit intrude, input bit stall, input string req,
                      output int cycles, output int loops);
    logic [15:0] cur = base;
    int le = (len == 0) ? 1 : len;
    logic [15:0] exitpc = base + 16'(3 + le);
    logic [15:0] lastpc = base + 16'(2 + le);
    int held = 0;
    int guard = 0;
    bit tgt_ok = 1'b1;
    bit stall_ok = 1'b1;
    bit busy_seen = 1'b0;
    cycles = 0;
    loops = 0;
    while (cur != exitpc && guard < 100000) begin
      guard++;
      @(negedge clk);
      pc = cur;
      advance = 1'b1;
      cmd_valid = (cycles == 0);
      cmd_count = 9'(cnt);
      cmd_len = 6'(len);
      if (cycles > 0 && intrude && busy) begin
        cmd_valid = 1'b1; cmd_count = 9'd5; cmd_len = 6'd2;
      end
      if (stall && cur == lastpc && held < 2) begin
        advance = 1'b0; held++;
      end
      #2;
      if (cycles == 1 && busy) busy_seen = 1'b1;
      if (advance) begin
        cycles++;
        held = 0;
        if (pc_ovr_valid) begin
          loops++;
          if (pc_ovr != base + 16'd3) tgt_ok = 1'b0;
          cur = pc_ovr;
        end else cur = cur + 16'd1;
      end else if (pc_ovr_valid) stall_ok = 1'b0;
    end
    @(negedge clk);
    cmd_valid = 1'b0; advance = 1'b0;
    #2;
    check(tgt_ok, {req, " R3 override target"}, 0, 0);
    check(busy_seen, {req, " R2 busy after command"}, 0, 1);
    check(!busy, {req, " R6 busy cleared after final pass"}, int'(busy), 0);
    if (stall) check(stall_ok, {req, " R8 no override while stalled"}, 0, 0);
  endtask

  task automatic t_reset();
    #2;
    check(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
    check(pc_ovr_valid == 1'b0, "R1 override at reset", int'(pc_ovr_valid), 0);
  endtask

  task automatic t_loop(input logic [15:0] base, input int cnt, input int len, input string req);
    int cyc, lp;
    int passes = (cnt == 0) ? 1 : cnt;
    int le = (len == 0) ? 1 : len;
    exec(base, cnt, len, 1'b0, 1'b0, req, cyc, lp);
    check(cyc == 3 + le * passes, {req, " total cycles"}, cyc, 3 + le * passes);
    check(lp == passes - 1, {req, " loop-backs"}, lp, passes - 1);
  endtask

  task automatic t_intrude();
    int cyc, lp;
    exec(16'h0200, 4, 3, 1'b1, 1'b0, "R7", cyc, lp);
    check(cyc == 15, "R7 cycles with foreign commands", cyc, 15);
    check(lp == 3, "R7 loop-backs with foreign commands", lp, 3);
  endtask

  task automatic t_stall();
    int cyc, lp;
    exec(16'h0300, 3, 2, 1'b0, 1'b1, "R8", cyc, lp);
    check(cyc == 9, "R8 advance cycles with stalls", cyc, 9);
    check(lp == 2, "R8 loop-backs with stalls", lp, 2);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_loop(16'h0010, 32, 3, "R3 3x32");
    t_loop(16'h0100, 256, 1, "R4 len1 x256");
    t_loop(16'h1000, 511, 63, "R4 max count and length");
    t_loop(16'h0040, 0, 4, "R5 count zero");
    t_loop(16'h0050, 1, 4, "R5 count one");
    t_loop(16'h0060, 3, 0, "R9 length zero");
    t_intrude();
    t_stall();
    t_loop(16'hFFF0, 2, 5, "R3 wrap near top");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule